// File: doc/BRIEF.md
# Multidrop Address-Wake UART Channel

This block is one asynchronous serial channel with an 8-entry transmit queue and an 8-entry receive queue. A 2-bit mode field chooses even parity, odd parity, no parity or multidrop operation. In multidrop operation the bit that would hold parity carries an address/data flag instead. On the transmit side this flag comes from a control register bit and not from the queued byte. On the receive side the flag decides which frames are kept.

A sleeping station leaves its receiver disabled while the line stays in multidrop mode. It then collects only address frames, plus any frame whose stop bit was bad. Software checks the address and sets the receiver enable when the address matches. From then on every frame is kept, whatever its flag. Each kept byte has a 3-bit status word beside it: the received flag (or the parity error in the parity modes), the framing error and the break indication. Bit timing comes from a clock-enable input pulsing at sixteen times the bit rate.

Top module: `mdu_channel`

## Requirements
- R1: The control register is loaded from `reg_wdata` when `reg_wr` is high, and resets to 0. Its fields are: [1:0] mode (00 even parity, 01 odd parity, 10 no parity, 11 multidrop), [3:2] data length (0..3 means 5..8 bits), [4] two stop bits, [5] receiver enable, [6] transmitter enable, [7] address/data flag for transmission.
- R2: A transmitted frame is a low start bit, then the data bits LSB first, then one flag bit (omitted in no-parity mode), then one or two high stop bits. Each bit lasts 16 `baud_tick` pulses.
- R3: In multidrop mode the transmitted flag equals control bit 7 as it stood when the byte left the transmit queue. A change made while a frame is being sent applies from the next frame on.
- R4: `tx_empty` is high only when the transmit queue is empty and the last stop bit has finished. With `baud_tick` held high, it rises 16 × (frame bits) cycles after `txd` falls. `txd` is high whenever `tx_empty` is high.
- R5: In multidrop mode with the receiver disabled, a frame with a good stop bit enters the receive queue only if its flag is 1. A frame with flag 0 is discarded.
- R6: In multidrop mode with the receiver enabled, every frame enters the receive queue. Its received flag appears in `rx_stat[0]`.
- R7: In the parity modes, `rx_stat[0]` reports a parity error. Even parity expects an even count of ones over data plus parity bit, and odd parity expects an odd count. In any non-multidrop mode a disabled receiver discards every frame.
- R8: A low stop bit sets `rx_stat[1]` (framing error). If in addition all data bits and the flag are 0, `rx_stat[2]` (break) is set. Such frames are kept when the receiver is enabled or the mode is multidrop, whatever the enable. After a bad stop bit the receiver waits for the line to go high before it looks for a new start bit.
- R9: A kept frame that finds the receive queue full and not being read is dropped, and `rx_overrun` is set. `rx_overrun` stays high until the next `rx_rd`.
- R10: After reset, `txd` is high, `tx_empty` is high, and `tx_full`, `rx_rdy` and `rx_overrun` are low.
- R11: Both queues are first-in first-out and hold 8 entries. `tx_full` flags a full transmit queue and a write to a full queue is dropped. `rx_rdy` flags a non-empty receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Enable at 16 times the bit rate |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register value |
| tx_wr | input | 1 | Push a byte into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue and shifter both idle |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 8 | Head byte of the receive queue |
| rx_stat | output | 3 | Head status: [2] break, [1] framing error, [0] flag or parity error |
| rx_rdy | output | 1 | Receive queue not empty |
| rx_overrun | output | 1 | Sticky overrun indication |

## Verification
Assertions check three things on every cycle. First, a sleeping multidrop receiver never presents a new head entry that lacks either the address flag or a framing error. Second, `txd` holds steady between bit boundaries and stays high whenever `tx_empty` is high. Third, neither queue moves past full or empty. Other behaviour can only be shown by the bench's scenarios, which compare each decoded frame and each queue entry with the expected value. These cover the exact frame layouts in each mode, parity values, the timing at which the transmit flag is latched, the precise cycle at which `tx_empty` rises, break and framing reports, and overrun.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    PAR_EVEN = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_NONE = 2'b10,
    PAR_ADDR = 2'b11
  } par_mode_e;

  // Control register, bit 7 down to bit 0
  typedef struct packed {
    logic      ad;
    logic      tx_en;
    logic      rx_en;
    logic      stop2;
    logic [1:0] len;
    par_mode_e mode;
  } ctrl_t;

  typedef struct packed {
    logic brk;
    logic fe;
    logic flag;
  } rx_stat_t;

  localparam int unsigned MAX_DATA = 8;

  function automatic logic [3:0] num_data(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic has_flag(input par_mode_e m);
    return m != PAR_NONE;
  endfunction

  function automatic logic [7:0] data_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

endpackage

// File: rtl/mdu_fifo.sv
module mdu_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  // DEPTH must be a power of two
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;
  logic         do_push, do_pop;

  always_comb begin
    empty   = (wp_q == rp_q);
    full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    do_pop  = pop && !empty;
    do_push = push && (!full || do_pop);
    wp_d    = wp_q + (AW+1)'(do_push);
    rp_d    = rp_q + (AW+1)'(do_pop);
    rdata   = mem[rp_q[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q[AW-1:0]] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty); // R11

endmodule

// File: rtl/mdu_tx.sv
module mdu_tx
  import mdu_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  ctrl_t      ctrl,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       fifo_pop,
  output logic       txd,
  output logic       busy
);
  localparam int unsigned FW = 1 + MAX_DATA + 1 + 2;
  localparam int unsigned CW = $clog2(OSR);

  logic          busy_q, busy_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    left_q, left_d;

  logic [FW-1:0] frame;
  logic [3:0]    nd, nbits;
  logic [7:0]    dm;
  logic          flag_bit;

  // Frame image built from the head byte and the control register
  always_comb begin
    nd = num_data(ctrl.len);
    dm = fifo_data & data_mask(ctrl.len);
    case (ctrl.mode)
      PAR_EVEN: flag_bit = ^dm;
      PAR_ODD:  flag_bit = ~^dm;
      PAR_ADDR: flag_bit = ctrl.ad;
      default:  flag_bit = 1'b1;
    endcase
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < int'(nd)) frame[i+1] = dm[i];
    end
    if (has_flag(ctrl.mode)) frame[4'(nd + 4'd1)] = flag_bit;
    nbits = 4'd2 + nd + {3'b000, has_flag(ctrl.mode)} + {3'b000, ctrl.stop2};
  end

  always_comb begin
    busy_d   = busy_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    left_d   = left_q;
    fifo_pop = 1'b0;
    if (!busy_q) begin
      if (ctrl.tx_en && !fifo_empty) begin
        fifo_pop = 1'b1;
        busy_d   = 1'b1;
        sh_d     = frame;
        cnt_d    = '0;
        left_d   = nbits;
      end
    end else if (tick) begin
      if (cnt_q == CW'(OSR-1)) begin
        cnt_d  = '0;
        sh_d   = {1'b1, sh_q[FW-1:1]};
        left_d = left_q - 4'd1;
        if (left_q == 4'd1) busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
    end
  end

  assign txd  = sh_q[0];
  assign busy = busy_q;

  AST_TX_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !($past(tick) && $past(cnt_q) == CW'(OSR-1)))
      |-> $stable(txd)); // R2

endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
  import mdu_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  ctrl_t      ctrl,
  output logic       frm_valid,
  output logic [7:0] frm_data,
  output rx_stat_t   frm_stat
);
  localparam int unsigned CW   = $clog2(OSR);
  localparam int unsigned HALF = OSR / 2;
  localparam int unsigned BW   = MAX_DATA + 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_DONE, S_WAITHI} st_e;

  logic          rx_s1, rx_s2;
  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    idx_q, idx_d;
  logic [BW-1:0] buf_q, buf_d;

  logic [3:0] nd, last;
  logic       hf, fb, stop_ok;
  logic [7:0] dm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
    end
  end

  always_comb begin
    nd      = num_data(ctrl.len);
    hf      = has_flag(ctrl.mode);
    last    = nd + {3'b000, hf};
    dm      = buf_q[7:0] & data_mask(ctrl.len);
    fb      = buf_q[nd];
    stop_ok = buf_q[last];
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    buf_d = buf_q;
    case (st_q)
      S_IDLE: begin
        cnt_d = '0;
        if (tick && !rx_s2) st_d = S_START;
      end
      S_START: if (tick) begin
        if (cnt_q == CW'(HALF-1)) begin
          cnt_d = '0;
          idx_d = '0;
          st_d  = rx_s2 ? S_IDLE : S_BITS;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      S_BITS: if (tick) begin
        if (cnt_q == CW'(OSR-1)) begin
          cnt_d        = '0;
          buf_d[idx_q] = rx_s2;
          if (idx_q == last) st_d = S_DONE;
          else               idx_d = idx_q + 4'd1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      S_DONE:   st_d = stop_ok ? S_IDLE : S_WAITHI;
      S_WAITHI: if (rx_s2) st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      buf_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      buf_q <= buf_d;
    end
  end

  always_comb begin
    frm_valid     = (st_q == S_DONE);
    frm_data      = dm;
    frm_stat.fe   = !stop_ok;
    frm_stat.brk  = !stop_ok && (dm == 8'h00) && !(hf && fb);
    case (ctrl.mode)
      PAR_EVEN: frm_stat.flag = fb != (^dm);
      PAR_ODD:  frm_stat.flag = fb != (~^dm);
      PAR_ADDR: frm_stat.flag = fb;
      default:  frm_stat.flag = 1'b0;
    endcase
  end

endmodule

// File: rtl/mdu_channel.sv
module mdu_channel
  import mdu_pkg::*;
#(
  parameter int unsigned OSR      = 16,
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  output logic       tx_full,
  output logic       tx_empty,
  output logic       txd,
  input  logic       rxd,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic [2:0] rx_stat,
  output logic       rx_rdy,
  output logic       rx_overrun
);
  localparam int unsigned SW = $bits(rx_stat_t);

  ctrl_t      ctrl_q, ctrl_d;
  logic       ovr_q, ovr_d;

  logic       txf_empty, txf_pop, tx_busy;
  logic [7:0] txf_data;

  logic       frm_valid, accept;
  logic [7:0] frm_data;
  rx_stat_t   frm_stat;
  logic       rxf_full, rxf_empty, rsf_full, rsf_empty;
  logic       md_sleep;

  always_comb begin
    ctrl_d   = reg_wr ? ctrl_t'(reg_wdata) : ctrl_q;
    md_sleep = (ctrl_q.mode == PAR_ADDR) && !ctrl_q.rx_en;
    // Address filter: sleeping multidrop receiver keeps address and error frames
    accept   = frm_valid &&
               (ctrl_q.rx_en ||
                ((ctrl_q.mode == PAR_ADDR) && (frm_stat.flag || frm_stat.fe)));
    ovr_d    = (ovr_q && !rx_rd) || (accept && rxf_full && !rx_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ovr_q  <= ovr_d;
    end
  end

  mdu_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_data), .pop(txf_pop),
    .rdata(txf_data), .full(tx_full), .empty(txf_empty)
  );

  mdu_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .ctrl(ctrl_q),
    .fifo_empty(txf_empty), .fifo_data(txf_data), .fifo_pop(txf_pop),
    .txd(txd), .busy(tx_busy)
  );

  mdu_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .ctrl(ctrl_q),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_stat(frm_stat)
  );

  mdu_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(accept), .wdata(frm_data), .pop(rx_rd),
    .rdata(rx_data), .full(rxf_full), .empty(rxf_empty)
  );

  mdu_fifo #(.W(SW), .DEPTH(RX_DEPTH)) u_rsq (
    .clk(clk), .rst_n(rst_n), .push(accept), .wdata(frm_stat), .pop(rx_rd),
    .rdata(rx_stat), .full(rsf_full), .empty(rsf_empty)
  );

  assign tx_empty   = !tx_busy && txf_empty;
  assign rx_rdy     = !rxf_empty;
  assign rx_overrun = ovr_q;

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd); // R4
  AST_SLEEP_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_rdy) && $past(md_sleep)) |-> (rx_stat[0] || rx_stat[1])); // R5
  AST_QUEUES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_empty == rsf_empty) && (rxf_full == rsf_full)); // R6

endmodule

// File: tb/mdu_channel_bench.sv
module mdu_channel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OSR = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_full, tx_empty, txd;
  logic       rxd = 1'b1;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic [2:0] rx_stat;
  logic       rx_rdy, rx_overrun;

  int checks = 0;
  int fails  = 0;

  // line format assumed by the bench driver and monitor
  int b_nd = 8;
  bit b_par = 1'b1;
  bit b_stop2 = 1'b0;

  typedef struct { logic [7:0] d; logic [2:0] s; string tag; } rx_item_t;
  typedef struct { logic [7:0] d; logic f; string tag; } tx_item_t;
  rx_item_t rxq[$];
  tx_item_t txq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdu_channel u_mdu_channel (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full),
    .tx_empty(tx_empty), .txd(txd), .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_stat(rx_stat), .rx_rdy(rx_rdy), .rx_overrun(rx_overrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr_tx(input logic [7:0] v);
    @(negedge clk); tx_wr = 1'b1; tx_data = v;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  // driver: shapes one serial frame on rxd
  task automatic send_rx(input logic [7:0] d, input logic f, input logic stp);
    @(negedge clk); rxd = 1'b0;
    repeat (OSR) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (i < b_nd) begin rxd = d[i]; repeat (OSR) @(negedge clk); end
    end
    if (b_par) begin rxd = f; repeat (OSR) @(negedge clk); end
    rxd = stp; repeat (OSR) @(negedge clk);
    rxd = 1'b1; repeat (2*OSR) @(negedge clk);
  endtask

  task automatic exp_rx(input logic [7:0] d, input logic [2:0] s, input string tag);
    rx_item_t it;
    it.d = d; it.s = s; it.tag = tag;
    rxq.push_back(it);
  endtask

  // monitor side of the receive scoreboard
  task automatic drain_rx(input string tag);
    rx_item_t it;
    while (rxq.size() != 0) begin
      it = rxq.pop_front();
      @(negedge clk);
      chk(rx_rdy == 1'b1, {it.tag, " rx_rdy"}, 32'(rx_rdy), 32'd1);
      chk(rx_data == it.d, {it.tag, " data"}, 32'(rx_data), 32'(it.d));
      chk(rx_stat == it.s, {it.tag, " status"}, 32'(rx_stat), 32'(it.s));
      rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
    end
    @(negedge clk);
    chk(rx_rdy == 1'b0, {tag, " queue drained"}, 32'(rx_rdy), 32'd0);
  endtask

  task automatic exp_tx(input logic [7:0] d, input logic f, input string tag);
    tx_item_t it;
    it.d = d; it.f = f; it.tag = tag;
    txq.push_back(it);
  endtask

  task automatic wait_tx_idle();
    repeat (3) @(negedge clk);
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic time_tx(input int exp_cycles, input string tag);
    int n;
    do @(negedge clk); while (txd !== 1'b0);
    n = 0;
    while (!tx_empty) begin @(negedge clk); n++; end
    chk(n == exp_cycles, tag, 32'(n), 32'(exp_cycles));
  endtask

  // monitor: decodes txd frames and compares to the expected queue
  initial begin
    logic [7:0] d;
    logic f, s, s2;
    tx_item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        d = '0; f = 1'b0; s2 = 1'b1;
        repeat (OSR/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          if (i < b_nd) begin repeat (OSR) @(negedge clk); d[i] = txd; end
        end
        if (b_par) begin repeat (OSR) @(negedge clk); f = txd; end
        repeat (OSR) @(negedge clk); s = txd;
        if (b_stop2) begin repeat (OSR) @(negedge clk); s2 = txd; end
        if (txq.size() == 0) begin
          chk(1'b0, "R11 unexpected frame", 32'(d), 32'hFFFF);
        end else begin
          it = txq.pop_front();
          chk(d == it.d, {it.tag, " tx data"}, 32'(d), 32'(it.d));
          if (b_par) chk(f == it.f, {it.tag, " tx flag"}, 32'(f), 32'(it.f));
          chk(s && s2, "R2 stop bits high", 32'({s, s2}), 32'd3);
        end
        repeat (OSR/2 - 1) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(txd == 1'b1, "R10 txd idle", 32'(txd), 32'd1);
    chk(tx_empty == 1'b1, "R10 tx_empty", 32'(tx_empty), 32'd1);
    chk(tx_full == 1'b0, "R10 tx_full", 32'(tx_full), 32'd0);
    chk(rx_rdy == 1'b0, "R10 rx_rdy", 32'(rx_rdy), 32'd0);
    chk(rx_overrun == 1'b0, "R10 overrun", 32'(rx_overrun), 32'd0);

    // R1 multidrop, 8 bits, 1 stop, receiver asleep
    b_nd = 8; b_par = 1'b1; b_stop2 = 1'b0;
    wr_ctrl(8'h0F);
    send_rx(8'h55, 1'b0, 1'b1);
    chk(rx_rdy == 1'b0, "R5 data frame discarded", 32'(rx_rdy), 32'd0);
    send_rx(8'hA3, 1'b1, 1'b1);
    exp_rx(8'hA3, 3'b001, "R5 address kept");
    drain_rx("R5");

    // R6 receiver awake: all frames kept
    wr_ctrl(8'h2F);
    send_rx(8'h12, 1'b0, 1'b1);
    exp_rx(8'h12, 3'b000, "R6 data frame");
    send_rx(8'h81, 1'b1, 1'b1);
    exp_rx(8'h81, 3'b001, "R6 address frame");
    drain_rx("R6");

    // R8 errors while asleep
    wr_ctrl(8'h0F);
    send_rx(8'h34, 1'b0, 1'b0);
    exp_rx(8'h34, 3'b010, "R8 framing error");
    send_rx(8'h00, 1'b0, 1'b0);
    exp_rx(8'h00, 3'b110, "R8 break");
    drain_rx("R8");

    // R9 overrun
    wr_ctrl(8'h2F);
    for (int i = 0; i < 9; i++) begin
      send_rx(8'(i + 8'h60), 1'b0, 1'b1);
      if (i < 8) exp_rx(8'(i + 8'h60), 3'b000, "R9 R11 queued order");
    end
    @(negedge clk);
    chk(rx_overrun == 1'b1, "R9 overrun set", 32'(rx_overrun), 32'd1);
    drain_rx("R9");
    chk(rx_overrun == 1'b0, "R9 overrun cleared", 32'(rx_overrun), 32'd0);

    // R7 even parity, 7 bits
    b_nd = 7;
    wr_ctrl(8'h28);
    send_rx(8'h45, 1'b1, 1'b1);
    exp_rx(8'h45, 3'b000, "R1 R7 parity good");
    send_rx(8'h45, 1'b0, 1'b1);
    exp_rx(8'h45, 3'b001, "R7 parity error");
    drain_rx("R7");
    wr_ctrl(8'h08);
    send_rx(8'h33, 1'b1, 1'b1);
    send_rx(8'h00, 1'b0, 1'b0);
    @(negedge clk);
    chk(rx_rdy == 1'b0, "R7 disabled normal mode discards", 32'(rx_rdy), 32'd0);

    // R2 R3 R4 transmit multidrop, address flag 1
    b_nd = 8; b_par = 1'b1; b_stop2 = 1'b0;
    wr_ctrl(8'hCF);
    exp_tx(8'h3C, 1'b1, "R2 R3 address frame");
    wr_tx(8'h3C);
    time_tx(16 * 11, "R4 tx_empty timing 8-bit");
    repeat (4) @(negedge clk);

    // R3 flag change during a frame applies to the next one
    exp_tx(8'h11, 1'b1, "R3 latched flag");
    exp_tx(8'h22, 1'b0, "R3 new flag");
    wr_tx(8'h11);
    wr_tx(8'h22);
    do @(negedge clk); while (txd !== 1'b0);
    wr_ctrl(8'h4F);
    wait_tx_idle();
    repeat (4) @(negedge clk);

    // R2 R4 odd parity, 5 bits, two stop bits
    b_nd = 5; b_par = 1'b1; b_stop2 = 1'b1;
    wr_ctrl(8'h51);
    exp_tx(8'h1B, 1'b1, "R2 odd parity frame");
    wr_tx(8'h1B);
    time_tx(16 * 9, "R4 tx_empty timing 5-bit 2-stop");
    repeat (4) @(negedge clk);

    // R11 transmit queue full, ninth byte dropped
    b_nd = 8; b_par = 1'b1; b_stop2 = 1'b0;
    wr_ctrl(8'h8F);
    for (int i = 0; i < 8; i++) begin
      wr_tx(8'(8'hC0 + i));
      exp_tx(8'(8'hC0 + i), 1'b1, "R11 tx order");
    end
    chk(tx_full == 1'b1, "R11 tx_full", 32'(tx_full), 32'd1);
    wr_tx(8'hEE);
    wr_ctrl(8'hCF);
    wait_tx_idle();
    repeat (300) @(negedge clk);
    chk(txq.size() == 0, "R11 all queued frames sent", 32'(txq.size()), 32'd0);
    chk(txd == 1'b1 && tx_empty == 1'b1, "R4 idle after queue drains", 32'({txd, tx_empty}), 32'd3);

    summary();
  end

endmodule